// File: doc/BRIEF.md
# Translation Lookaside Buffer with Cyclic Victim Pointer

This block is the translation cache of a device-side address translator. It holds `ENTRIES` fully associative entries. Each entry has a tag half and a data half. The tag half holds a page-aligned virtual base, a page-size code, a valid bit and a preserved flag. The data half holds a page-aligned physical base and an attribute field. A lookup port takes a device virtual address. One clock later it reports hit or miss. On a hit it also returns the physical address (physical base plus page offset) and the entry's attributes. A miss is only reported; the block does nothing else about it.

Software manages the contents through a command stream with a valid/ready handshake. A command moves when `cmd_valid` and `cmd_ready` are both high at a rising edge. `cmd_ready` drops for exactly the one cycle that follows an accepted load that was not refused. During that cycle the entry is written, and a sender must hold its next command until ready returns. The lookup port has no back-pressure: every lookup is taken. The result and read-back outputs are one-cycle pulses with no ready, so the consumer must capture them when their valid is high.

The commands are: set the victim pointer, read back the entry at the victim pointer, load the staged tag and data at the victim pointer, flush the entries whose page contains an address, and flush everything. The victim pointer is visible at a port. It steps forward cyclically after each load. There is no preserved region: the lowest replaceable index is always 0.

Top module: `xlat_tlb`

## Requirements
- R1: While reset is asserted and after it is released, every entry is invalid, `victim` is 0, `cmd_ready` is 1, and `res_valid`, `rd_valid` and `load_busy` are 0. A lookup issued right after reset misses.
- R2: The page-size code is `00`=16 MB, `01`=1 MB, `10`=64 KB and `11`=4 KB. A lookup hits a valid entry when the address, masked to that entry's page size, equals the entry's stored base. On a hit, `res_pa` is the physical base OR'd with the address bits below the page size, and `res_attr` is the entry's attributes. An address one past the end of a page misses that page.
- R3: A lookup presented with `lk_valid` at edge k sets `res_valid` after edge k for exactly that cycle. The result reflects the entries as they stood before edge k.
- R4: If several entries match, the lowest index supplies `res_pa` and `res_attr`, and `res_multi` is raised together with `res_hit`.
- R5: The command with `cmd_op`=0 sets `victim` to `cmd_index` at the accepting edge.
- R6: The command with `cmd_op`=1 raises `rd_valid` for one cycle after the accepting edge. It returns the valid bit, base, size code, preserved flag, physical base and attributes of the entry at `victim`.
- R7: The command with `cmd_op`=2 (load) invalidates the slot at `victim` at the accepting edge and holds `cmd_ready` low for the next cycle. At the following edge it writes the staged fields, masked to page alignment, into that slot and marks it valid.
- R8: Each completed load advances `victim` by one, and `victim` wraps from `ENTRIES`-1 to 0.
- R9: A load accepted while every entry is valid is refused. `load_busy` is high for the one cycle after the accepting edge, `cmd_ready` stays high, and neither the entries nor `victim` change.
- R10: The command with `cmd_op`=3 invalidates every valid entry whose base is at or below `cmd_va` and whose end (base plus page size) is above `cmd_va`. It leaves every other entry untouched.
- R11: The command with `cmd_op`=4 invalidates all entries and sets `victim` to 0.
- R12: The preserved flag is stored and read back only. Flush by address, flush all and replacement treat preserved entries like any other. Op codes 5 to 7 are accepted and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 3 | Command code (0 set victim, 1 read, 2 load, 3 flush address, 4 flush all) |
| cmd_index | input | IDX_W | New victim value for op 0 |
| cmd_va | input | ADDR_W | Virtual base for load, address for flush by address |
| cmd_size | input | 2 | Page-size code for load |
| cmd_pres | input | 1 | Preserved flag for load |
| cmd_pa | input | ADDR_W | Physical base for load |
| cmd_attr | input | ATTR_W | Attributes for load |
| load_busy | output | 1 | Pulse: a load was refused because all entries were valid |
| victim | output | IDX_W | Current victim pointer |
| rd_valid | output | 1 | Read-back result pulse |
| rd_entry_valid | output | 1 | Valid bit of the entry read back |
| rd_va | output | ADDR_W | Stored virtual base read back |
| rd_size | output | 2 | Page-size code read back |
| rd_pres | output | 1 | Preserved flag read back |
| rd_pa | output | ADDR_W | Physical base read back |
| rd_attr | output | ATTR_W | Attributes read back |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | ADDR_W | Lookup virtual address |
| res_valid | output | 1 | Lookup result pulse |
| res_hit | output | 1 | Lookup hit |
| res_multi | output | 1 | More than one entry matched |
| res_pa | output | ADDR_W | Translated physical address |
| res_attr | output | ATTR_W | Attributes of the matching entry |

## Verification
The assertions assume that `lk_valid` and `cmd_valid` stay low while reset is asserted. They also assume that `cmd_index` never names a slot at or beyond `ENTRIES`. The bench holds both inputs low through reset and draws victim indices only from 0 to `ENTRIES`-1. It drives inputs on the falling edge and offers a command only when it has seen `cmd_ready` high, so no command is offered during the load write cycle. The random phase reuses a handful of overlapping bases across all four page sizes. This produces multiple hits, full-buffer refusals and flushes that straddle page ends.

// File: rtl/xtlb_pkg.sv
package xtlb_pkg;
  localparam logic [2:0] OP_SETVIC = 3'd0;
  localparam logic [2:0] OP_READ   = 3'd1;
  localparam logic [2:0] OP_LOAD   = 3'd2;
  localparam logic [2:0] OP_FLADDR = 3'd3;
  localparam logic [2:0] OP_FLALL  = 3'd4;

  localparam logic [1:0] PG_16M = 2'b00;
  localparam logic [1:0] PG_1M  = 2'b01;
  localparam logic [1:0] PG_64K = 2'b10;
  localparam logic [1:0] PG_4K  = 2'b11;

  function automatic int unsigned pg_shift(logic [1:0] sz);
    case (sz)
      PG_16M:  return 24;
      PG_1M:   return 20;
      PG_64K:  return 16;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/xtlb_ctrl.sv
module xtlb_ctrl #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_index,
  input  logic             all_valid,
  output logic             cmd_ready,
  output logic [IDX_W-1:0] victim,
  output logic             load_busy,
  output logic             wr_en,
  output logic             clr_slot_en,
  output logic             clr_all,
  output logic             fl_en,
  output logic             rd_en
);
  import xtlb_pkg::*;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic pend_q, busy_q, acc, is_load, load_go, set_vic;
  logic [IDX_W-1:0] vic_q;

  assign cmd_ready   = !pend_q;
  assign acc         = cmd_valid && cmd_ready;
  assign is_load     = acc && (cmd_op == OP_LOAD);
  assign load_go     = is_load && !all_valid;
  assign set_vic     = acc && (cmd_op == OP_SETVIC);
  assign clr_slot_en = load_go;
  assign wr_en       = pend_q;
  assign clr_all     = acc && (cmd_op == OP_FLALL);
  assign fl_en       = acc && (cmd_op == OP_FLADDR);
  assign rd_en       = acc && (cmd_op == OP_READ);
  assign victim      = vic_q;
  assign load_busy   = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      vic_q  <= '0;
    end else begin
      pend_q <= load_go;
      busy_q <= is_load && all_valid;
      if (clr_all)      vic_q <= '0;
      else if (set_vic) vic_q <= cmd_index;
      else if (pend_q)  vic_q <= (vic_q == LAST) ? '0 : vic_q + 1'b1;
    end
  end

  assert_ready_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> !cmd_ready);
  assert_ready_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |=> cmd_ready);
  assert_set_victim_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_vic |=> (victim == $past(cmd_index)));
  assert_victim_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (victim == '0));
endmodule

// File: rtl/xtlb_store.sv
module xtlb_store #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int ATTR_W  = 4,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_va,
  input  logic [1:0]        wr_size,
  input  logic              wr_pres,
  input  logic [ADDR_W-1:0] wr_pa,
  input  logic [ATTR_W-1:0] wr_attr,
  input  logic              clr_slot_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic              clr_all,
  input  logic              fl_en,
  input  logic [ADDR_W-1:0] fl_va,
  input  logic [ADDR_W-1:0] lk_va,
  output logic [ENTRIES-1:0] vld_vec,
  output logic [ENTRIES-1:0] hit_vec,
  output logic [ADDR_W-1:0] arr_va   [ENTRIES],
  output logic [1:0]        arr_size [ENTRIES],
  output logic              arr_pres [ENTRIES],
  output logic [ADDR_W-1:0] arr_pa   [ENTRIES],
  output logic [ATTR_W-1:0] arr_attr [ENTRIES]
);
  import xtlb_pkg::*;

  logic [ADDR_W-1:0]  wmask;
  logic [ENTRIES-1:0] fl_vec;

  assign wmask = {ADDR_W{1'b1}} << pg_shift(wr_size);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic              vld_q, pres_q;
    logic [ADDR_W-1:0] va_q, pa_q, emask;
    logic [1:0]        sz_q;
    logic [ATTR_W-1:0] at_q;
    logic              kill, wsel;

    assign emask      = {ADDR_W{1'b1}} << pg_shift(sz_q);
    assign hit_vec[g] = vld_q && ((lk_va & emask) == va_q);
    assign fl_vec[g]  = vld_q && ((fl_va & emask) == va_q);
    assign wsel       = wr_en && (wr_idx == IDX_W'(g));
    assign kill       = clr_all || (fl_en && fl_vec[g]) ||
                        (clr_slot_en && (clr_idx == IDX_W'(g)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        pres_q <= 1'b0;
        va_q   <= '0;
        pa_q   <= '0;
        sz_q   <= '0;
        at_q   <= '0;
      end else begin
        if (kill)      vld_q <= 1'b0;
        else if (wsel) vld_q <= 1'b1;
        if (wsel) begin
          va_q   <= wr_va & wmask;
          pa_q   <= wr_pa & wmask;
          sz_q   <= wr_size;
          pres_q <= wr_pres;
          at_q   <= wr_attr;
        end
      end
    end

    assign vld_vec[g]  = vld_q;
    assign arr_va[g]   = va_q;
    assign arr_size[g] = sz_q;
    assign arr_pres[g] = pres_q;
    assign arr_pa[g]   = pa_q;
    assign arr_attr[g] = at_q;
  end

  assert_flush_all_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (vld_vec == '0));
  assert_load_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_vec[$past(wr_idx)]);
  assert_flush_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fl_en |=> ((vld_vec & $past(fl_vec)) == '0));
endmodule

// File: rtl/xtlb_pick.sv
module xtlb_pick #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] hit_vec,
  output logic               found,
  output logic               multi,
  output logic [IDX_W-1:0]   sel_idx
);
  always_comb begin
    sel_idx = '0;
    found   = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        sel_idx = IDX_W'(i);
        found   = 1'b1;
      end
    end
  end

  assign multi = (hit_vec & (hit_vec - 1'b1)) != '0;

  always_comb begin
    if (multi) assert_multi_has_hit_R4: assert (found);
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int ATTR_W  = 4,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_index,
  input  logic [ADDR_W-1:0] cmd_va,
  input  logic [1:0]        cmd_size,
  input  logic              cmd_pres,
  input  logic [ADDR_W-1:0] cmd_pa,
  input  logic [ATTR_W-1:0] cmd_attr,
  output logic              load_busy,
  output logic [IDX_W-1:0]  victim,
  output logic              rd_valid,
  output logic              rd_entry_valid,
  output logic [ADDR_W-1:0] rd_va,
  output logic [1:0]        rd_size,
  output logic              rd_pres,
  output logic [ADDR_W-1:0] rd_pa,
  output logic [ATTR_W-1:0] rd_attr,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_va,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_multi,
  output logic [ADDR_W-1:0] res_pa,
  output logic [ATTR_W-1:0] res_attr
);
  import xtlb_pkg::*;

  logic wr_en, clr_slot_en, clr_all, fl_en, rd_en, found, multi;
  logic [ENTRIES-1:0] vld_vec, hit_vec;
  logic [IDX_W-1:0]   sel_idx;
  logic [ADDR_W-1:0]  arr_va   [ENTRIES];
  logic [1:0]         arr_size [ENTRIES];
  logic               arr_pres [ENTRIES];
  logic [ADDR_W-1:0]  arr_pa   [ENTRIES];
  logic [ATTR_W-1:0]  arr_attr [ENTRIES];
  logic [ADDR_W-1:0]  st_va, st_pa, sel_mask;
  logic [1:0]         st_size;
  logic               st_pres;
  logic [ATTR_W-1:0]  st_attr;

  xtlb_ctrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_index(cmd_index), .all_valid(&vld_vec), .cmd_ready(cmd_ready),
    .victim(victim), .load_busy(load_busy), .wr_en(wr_en),
    .clr_slot_en(clr_slot_en), .clr_all(clr_all), .fl_en(fl_en), .rd_en(rd_en)
  );

  xtlb_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .ATTR_W(ATTR_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(victim), .wr_va(st_va),
    .wr_size(st_size), .wr_pres(st_pres), .wr_pa(st_pa), .wr_attr(st_attr),
    .clr_slot_en(clr_slot_en), .clr_idx(victim), .clr_all(clr_all),
    .fl_en(fl_en), .fl_va(cmd_va), .lk_va(lk_va), .vld_vec(vld_vec),
    .hit_vec(hit_vec), .arr_va(arr_va), .arr_size(arr_size),
    .arr_pres(arr_pres), .arr_pa(arr_pa), .arr_attr(arr_attr)
  );

  xtlb_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .hit_vec(hit_vec), .found(found), .multi(multi), .sel_idx(sel_idx)
  );

  assign sel_mask = {ADDR_W{1'b1}} << pg_shift(arr_size[sel_idx]);

  // staging of the load fields, written one cycle after acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_va <= '0; st_pa <= '0; st_size <= '0; st_pres <= 1'b0; st_attr <= '0;
    end else if (clr_slot_en) begin
      st_va <= cmd_va; st_pa <= cmd_pa; st_size <= cmd_size;
      st_pres <= cmd_pres; st_attr <= cmd_attr;
    end
  end

  // lookup result register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0; res_hit <= 1'b0; res_multi <= 1'b0;
      res_pa <= '0; res_attr <= '0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= lk_valid && found;
      res_multi <= lk_valid && multi;
      if (lk_valid) begin
        res_pa   <= arr_pa[sel_idx] | (lk_va & ~sel_mask);
        res_attr <= arr_attr[sel_idx];
      end
    end
  end

  // read-back register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0; rd_entry_valid <= 1'b0; rd_va <= '0; rd_size <= '0;
      rd_pres <= 1'b0; rd_pa <= '0; rd_attr <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_entry_valid <= vld_vec[victim];
        rd_va   <= arr_va[victim];
        rd_size <= arr_size[victim];
        rd_pres <= arr_pres[victim];
        rd_pa   <= arr_pa[victim];
        rd_attr <= arr_attr[victim];
      end
    end
  end

  assert_busy_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_busy |-> $past(&vld_vec));
  assert_busy_keeps_victim_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_busy |-> (victim == $past(victim)));
  assert_multi_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_multi) |-> res_hit);
  assert_res_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(lk_valid));
endmodule

// File: tb/test_xlat_tlb.sv
module test_xlat_tlb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int AW = 32;
  localparam int TW = 4;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_pres = 1'b0, lk_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [IW-1:0] cmd_index = '0;
  logic [AW-1:0] cmd_va = '0, cmd_pa = '0, lk_va = '0;
  logic [1:0] cmd_size = '0;
  logic [TW-1:0] cmd_attr = '0;
  logic cmd_ready, load_busy, rd_valid, rd_entry_valid, rd_pres;
  logic res_valid, res_hit, res_multi;
  logic [IW-1:0] victim;
  logic [AW-1:0] rd_va, rd_pa, res_pa;
  logic [1:0] rd_size;
  logic [TW-1:0] rd_attr, res_attr;

  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_tlb #(.ENTRIES(N), .ADDR_W(AW), .ATTR_W(TW)) i_xlat_tlb (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_index(cmd_index), .cmd_va(cmd_va), .cmd_size(cmd_size),
    .cmd_pres(cmd_pres), .cmd_pa(cmd_pa), .cmd_attr(cmd_attr),
    .load_busy(load_busy), .victim(victim), .rd_valid(rd_valid),
    .rd_entry_valid(rd_entry_valid), .rd_va(rd_va), .rd_size(rd_size),
    .rd_pres(rd_pres), .rd_pa(rd_pa), .rd_attr(rd_attr), .lk_valid(lk_valid),
    .lk_va(lk_va), .res_valid(res_valid), .res_hit(res_hit),
    .res_multi(res_multi), .res_pa(res_pa), .res_attr(res_attr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  longint m_va[N], m_pa[N];
  int m_sz[N], m_at[N];
  bit m_vld[N], m_pres[N];
  int m_vic = 0;
  bit m_pend = 0, m_ready = 1, m_busy = 0, m_rv = 0, m_hit = 0, m_multi = 0;
  longint m_rpa = 0;
  int m_rat = 0;
  bit m_rdv = 0, m_rdev = 0, m_rdpres = 0;
  longint m_rdva = 0, m_rdpa = 0;
  int m_rdsz = 0, m_rdat = 0;
  longint s_va = 0, s_pa = 0;
  int s_sz = 0, s_at = 0;
  bit s_pres = 0;

  function automatic longint pbytes(int sz);
    case (sz)
      0: return 64'h100_0000;
      1: return 64'h10_0000;
      2: return 64'h1_0000;
      default: return 64'h1000;
    endcase
  endfunction

  function automatic longint align(longint a, int sz);
    return a - (a % pbytes(sz));
  endfunction

  function automatic bit inside_pg(int i, longint a);
    return m_vld[i] && (m_va[i] <= a) && (a < m_va[i] + pbytes(m_sz[i]));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_vld[i] = 0; m_pres[i] = 0; m_va[i] = 0; m_pa[i] = 0; m_sz[i] = 0; m_at[i] = 0;
      end
      m_vic = 0; m_pend = 0; m_ready = 1; m_busy = 0; m_rv = 0; m_hit = 0;
      m_multi = 0; m_rdv = 0;
    end else begin
      int cnt;
      bit acc;
      longint a;
      a = longint'(lk_va);
      cnt = 0;
      for (int i = 0; i < N; i++) begin
        if (inside_pg(i, a)) begin
          if (cnt == 0) begin m_rpa = m_pa[i] + (a - m_va[i]); m_rat = m_at[i]; end
          cnt++;
        end
      end
      m_rv = lk_valid; m_hit = lk_valid && cnt > 0; m_multi = lk_valid && cnt > 1;
      acc = cmd_valid && m_ready;
      m_rdv = acc && cmd_op == 3'd1;
      if (m_rdv) begin
        m_rdev = m_vld[m_vic]; m_rdva = m_va[m_vic]; m_rdpa = m_pa[m_vic];
        m_rdsz = m_sz[m_vic]; m_rdat = m_at[m_vic]; m_rdpres = m_pres[m_vic];
      end
      m_busy = 0;
      if (m_pend) begin
        m_vld[m_vic] = 1; m_va[m_vic] = s_va; m_pa[m_vic] = s_pa; m_sz[m_vic] = s_sz;
        m_at[m_vic] = s_at; m_pres[m_vic] = s_pres;
        m_vic = (m_vic + 1) % N; m_pend = 0;
      end else if (acc) begin
        case (cmd_op)
          3'd0: m_vic = int'(cmd_index);
          3'd2: begin
            bit full;
            full = 1;
            for (int i = 0; i < N; i++) if (!m_vld[i]) full = 0;
            if (full) m_busy = 1;
            else begin
              m_vld[m_vic] = 0;
              s_sz = int'(cmd_size);
              s_va = align(longint'(cmd_va), s_sz);
              s_pa = align(longint'(cmd_pa), s_sz);
              s_at = int'(cmd_attr); s_pres = cmd_pres; m_pend = 1;
            end
          end
          3'd3: begin
            bit kill[N];
            for (int i = 0; i < N; i++) kill[i] = inside_pg(i, longint'(cmd_va));
            for (int i = 0; i < N; i++) if (kill[i]) m_vld[i] = 0;
          end
          3'd4: begin
            for (int i = 0; i < N; i++) m_vld[i] = 0;
            m_vic = 0;
          end
          default: ;
        endcase
      end
      m_ready = !m_pend;
    end
  end

  // comparison against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R7 cmd_ready", cmd_ready, m_ready);
      chk("R8 victim", victim, m_vic);
      chk("R9 load_busy", load_busy, m_busy);
      chk("R3 res_valid", res_valid, m_rv);
      if (m_rv) begin
        chk("R2 res_hit", res_hit, m_hit);
        chk("R4 res_multi", res_multi, m_multi);
        if (m_hit) begin
          chk("R2 res_pa", res_pa, m_rpa[AW-1:0]);
          chk("R4 res_attr", res_attr, m_rat);
        end
      end
      chk("R6 rd_valid", rd_valid, m_rdv);
      if (m_rdv) begin
        chk("R6 rd_entry_valid", rd_entry_valid, m_rdev);
        if (m_rdev) begin
          chk("R6 rd_va", rd_va, m_rdva[AW-1:0]);
          chk("R6 rd_pa", rd_pa, m_rdpa[AW-1:0]);
          chk("R6 rd_size", rd_size, m_rdsz);
          chk("R6 rd_attr", rd_attr, m_rdat);
          chk("R12 rd_pres", rd_pres, m_rdpres);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 200000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<200000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic issue(input logic [2:0] op, input int idx, input logic [AW-1:0] va,
                       input logic [1:0] sz, input bit pres, input logic [AW-1:0] pa,
                       input int at);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_index = IW'(idx); cmd_va = va; cmd_size = sz; cmd_pres = pres;
    cmd_pa = pa; cmd_attr = TW'(at); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic look(input logic [AW-1:0] a, input bit eh, input bit em,
                      input logic [AW-1:0] ep, input string tag);
    @(negedge clk);
    lk_valid = 1'b1; lk_va = a;
    @(negedge clk);
    lk_valid = 1'b0;
    chk({tag, " hit"}, res_hit, eh);
    chk({tag, " multi"}, res_multi, em);
    if (eh) chk({tag, " pa"}, res_pa, ep);
  endtask

  function automatic logic [AW-1:0] pick_va();
    logic [AW-1:0] bases[5];
    bases[0] = 32'h0000_0000; bases[1] = 32'h0000_3000; bases[2] = 32'h0003_0000;
    bases[3] = 32'h0010_0000; bases[4] = 32'h0500_0000;
    return bases[$urandom % 5] + AW'($urandom % 32'h2_0000);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ready in reset", cmd_ready, 1);
    chk("R1 victim in reset", victim, 0);
    chk("R1 res_valid in reset", res_valid, 0);
    rst_n = 1'b1;
    chk("R1 rd_valid after reset", rd_valid, 0);
    chk("R1 busy after reset", load_busy, 0);
    look(32'h0000_3000, 0, 0, 0, "R1 empty lookup");

    // loads into slots 0..4
    issue(3'd2, 0, 32'h0000_3000, 2'b11, 0, 32'h8000_0000, 5);
    chk("R7 ready low during write", cmd_ready, 0);
    @(negedge clk);
    chk("R8 victim after first load", victim, 1);
    issue(3'd2, 0, 32'h0500_0000, 2'b00, 0, 32'h1200_0000, 3);
    issue(3'd2, 0, 32'h0010_0000, 2'b01, 0, 32'h2000_0000, 1);
    issue(3'd2, 0, 32'h0003_0000, 2'b10, 0, 32'h3000_0000, 2);
    issue(3'd2, 0, 32'h0000_0000, 2'b01, 1, 32'h4000_0000, 7);
    look(32'h0500_0000, 1, 0, 32'h1200_0000, "R2 16M base");
    look(32'h05FF_FFF0, 1, 0, 32'h12FF_FFF0, "R2 16M top");
    look(32'h0600_0000, 0, 0, 0, "R2 16M end excluded");
    look(32'h0012_3456, 1, 0, 32'h2002_3456, "R2 1M page");
    look(32'h0000_3ABC, 1, 1, 32'h8000_0ABC, "R4 4K over 1M lowest wins");
    look(32'h0003_FFFF, 1, 1, 32'h3000_FFFF, "R4 64K over 1M lowest wins");
    look(32'h0000_5000, 1, 0, 32'h4000_5000, "R2 1M single");

    issue(3'd0, 6, 0, 0, 0, 0, 0);
    chk("R5 set victim", victim, 6);
    issue(3'd1, 0, 0, 0, 0, 0, 0);
    chk("R6 read invalid slot", rd_entry_valid, 0);
    issue(3'd0, 4, 0, 0, 0, 0, 0);
    issue(3'd1, 0, 0, 0, 0, 0, 0);
    chk("R6 read valid", rd_entry_valid, 1);
    chk("R6 read size", rd_size, 2'b01);
    chk("R6 read pa", rd_pa, 32'h4000_0000);
    chk("R12 read preserved", rd_pres, 1);

    issue(3'd3, 0, 32'h0000_3FFF, 0, 0, 0, 0);
    look(32'h0000_3010, 0, 0, 0, "R10 flushed 4K and preserved 1M (R12)");
    look(32'h0003_0000, 1, 0, 32'h3000_0000, "R10 64K untouched");
    issue(3'd3, 0, 32'h0600_0000, 0, 0, 0, 0);
    look(32'h0500_0000, 1, 0, 32'h1200_0000, "R10 end address not flushed");
    issue(3'd5, 0, 32'h0500_0000, 0, 0, 0, 0);
    look(32'h0500_0000, 1, 0, 32'h1200_0000, "R12 op5 no effect");

    for (int k = 0; k < 4; k++)
      issue(3'd2, 0, 32'h1000_0000 + 32'(k) * 32'h1000, 2'b11, 0, 32'h9000_0000 + 32'(k) * 32'h1000, k);
    @(negedge clk);
    chk("R8 victim wrapped", victim, 0);
    issue(3'd2, 0, 32'h2000_0000, 2'b11, 0, 32'hA000_0000, 9);
    issue(3'd2, 0, 32'h3000_0000, 2'b11, 0, 32'hB000_0000, 9);
    chk("R9 busy on full", load_busy, 1);
    chk("R9 ready stays high", cmd_ready, 1);
    @(negedge clk);
    chk("R9 victim unchanged", victim, 1);
    look(32'h3000_0000, 0, 0, 0, "R9 refused load absent");
    look(32'h1000_2004, 1, 0, 32'h9000_2004, "R7 loaded entry hits");

    issue(3'd4, 0, 0, 0, 0, 0, 0);
    chk("R11 victim cleared", victim, 0);
    look(32'h0500_0000, 0, 0, 0, "R11 all flushed");

    // random phase, model compared on every clock
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      lk_valid = 1'($urandom % 2);
      lk_va = pick_va();
      cmd_valid = 1'b0;
      if (cmd_ready && ($urandom % 3 == 0)) begin
        int r;
        r = int'($urandom % 16);
        cmd_op = (r < 2) ? 3'd0 : (r < 5) ? 3'd1 : (r < 11) ? 3'd2 :
                 (r < 14) ? 3'd3 : (r < 15) ? 3'd4 : 3'd5;
        cmd_index = IW'($urandom % N);
        cmd_va = pick_va();
        cmd_size = 2'($urandom % 4);
        cmd_pres = 1'($urandom % 2);
        cmd_pa = $urandom;
        cmd_attr = TW'($urandom);
        cmd_valid = 1'b1;
      end
    end
    @(negedge clk);
    cmd_valid = 1'b0; lk_valid = 1'b0;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule